// File: doc/BRIEF.md
# Buffered Serial Transmitter with Programmable Baud Divisor

This block is the send half of a classic byte-oriented serial port. A host reaches it through a small byte-wide register port with a two-bit address. A select bit in the control register decides what that port reaches. When the bit is clear, address 0 accepts outgoing bytes. When it is set, addresses 0 and 1 reach the low and high bytes of a 16-bit baud divisor.

Outgoing bytes wait in one of two places, depending on the control register. One is a single holding register, which a newer write overwrites. The other is a 16-entry queue, which refuses writes once it is full. A shifter takes each byte and sends it as a fixed frame: a start bit, eight data bits and a stop bit. A divisor-driven tick generator sets the rate, and each bit lasts sixteen ticks. An empty flag tells the host when it may write more data.

Top module: `uart_tx_top`

## Requirements
- R1: After reset, `txd` is 1 and `thr_empty` is 1. The control register (address 2) reads 0, both divisor bytes read 0, and status (address 3) reads 8'h01.
- R2: Each byte is sent as one frame with the least significant data bit first. The frame is a 0 start bit, the eight data bits and a 1 stop bit. Between frames the line stays at 1.
- R3: With divisor D ≠ 0, each bit lasts 16·D clocks. The start bit alone may be shortened by less than D clocks, because its ticks fall on a free-running grid.
- R4: While both divisor bytes are 0, no ticks occur, and a frame already started holds its current line level.
- R5: Control bit 1 is the latch select and bit 0 is the queue enable. With bit 1 set, address 0 reads and writes the divisor low byte, address 1 reads and writes the high byte, and no byte is queued for sending. With bit 1 clear, address 0 is a write-only data register that reads as 0, and writes to address 1 have no effect.
- R6: With the queue disabled, a data write while a byte is still waiting replaces that byte, so only the newest byte is sent.
- R7: With the queue enabled, up to 16 bytes wait in arrival order. A write while 16 bytes are waiting is discarded.
- R8: `thr_empty` is 1 exactly when no byte is waiting. It reads 0 in the cycle after an accepted data write. Status bit 0 mirrors it, and status bit 1 is 1 while a frame is being sent.
- R9: A control write that changes bit 0 discards every waiting byte, in both the holding register and the queue. A frame already being sent finishes normally.
- R10: Writing either divisor byte restarts the tick counter, so the next bit timing follows the new ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 data or divisor low, 1 divisor high, 2 control, 3 status |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data for `addr` |
| txd | output | 1 | Serial output, idles at 1 |
| thr_empty | output | 1 | No byte waiting to be sent |

## Verification
The bench tries the frame path with several byte patterns: alternating bits, single set bits at either end, all zeros and all ones. It runs them at divisors 1, 2 and 3, in both buffering modes. A wrong bit order, a missing start or stop bit, or a wrong bit length would each corrupt a different sample position. Stalling the line with a zero divisor lets several writes pile up. The bench can then tell overwrite apart from queueing, see the seventeenth write dropped, and see a mode change discard the backlog while the current frame still finishes. The length of the low stretch in an all-zero frame pins the bit period for two divisor values, one loaded after the other.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [1:0] {
    REG_DATA  = 2'd0,
    REG_DIVHI = 2'd1,
    REG_CTRL  = 2'd2,
    REG_STAT  = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic latch_sel;
    logic queue_en;
  } ctrl_t;

  localparam int unsigned OVERSAMPLE = 16;
  localparam int unsigned FRAME_BITS = 10;
endpackage

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic             div_zero;

  assign div_zero = (divisor == '0);

  always_ff @(posedge clk) begin
    if (rst || restart || div_zero) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == divisor - 1'b1) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  // R4: a divisor that has stayed zero yields no tick
  a_r4_no_tick_when_zero: assert property (@(posedge clk) disable iff (rst)
    (div_zero && $past(div_zero)) |-> !tick);

  // R10: a restart suppresses the tick that follows it
  a_r10_restart_clears: assert property (@(posedge clk) disable iff (rst)
    $past(restart) |-> !tick);
endmodule

// File: rtl/tx_byte_buffer.sv
module tx_byte_buffer #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         queue_en,
  input  logic         flush,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic         avail,
  output logic [W-1:0] head,
  output logic         empty
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] count;
  logic [W-1:0]  hold;
  logic          hold_v;
  logic          full, q_wr, q_pop, taken;

  assign full  = (count == CW'(DEPTH));
  assign q_wr  = queue_en && wr && !full;
  assign q_pop = queue_en && pop && (count != '0);
  assign taken = queue_en ? q_wr : wr;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (q_wr) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (q_wr)  wp <= nxt(wp);
      if (q_pop) rp <= nxt(rp);
      case ({q_wr, q_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      hold   <= '0;
      hold_v <= 1'b0;
    end else if (!queue_en) begin
      if (wr) begin
        hold   <= wdata;
        hold_v <= 1'b1;
      end else if (pop) begin
        hold_v <= 1'b0;
      end
    end
  end

  assign avail = queue_en ? (count != '0) : hold_v;
  assign head  = queue_en ? mem[rp] : hold;
  assign empty = !avail;

  a_r7_count_bound: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  // R7: a full queue stays full when a write arrives without a pop
  a_r7_full_drop: assert property (@(posedge clk) disable iff (rst)
    (queue_en && wr && full && !pop && !flush) |=> (count == CW'(DEPTH)));

  // R8: an accepted byte makes the buffer non-empty in the next cycle
  a_r8_empty_falls: assert property (@(posedge clk) disable iff (rst)
    (taken && !flush) |=> !empty);

  // R9: a flush leaves nothing waiting
  a_r9_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush |=> empty);
endmodule

// File: rtl/tx_shifter.sv
module tx_shifter
  import uart_tx_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         avail,
  input  logic [W-1:0] head,
  output logic         pop,
  output logic         txd,
  output logic         busy
);
  localparam int unsigned SW = $clog2(OVERSAMPLE);
  localparam int unsigned BW = $clog2(FRAME_BITS);

  logic [W:0]    frame;
  logic [SW-1:0] sub;
  logic [BW-1:0] bitn;

  assign pop = !busy && avail;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      txd   <= 1'b1;
      frame <= '1;
      sub   <= '0;
      bitn  <= '0;
    end else if (!busy) begin
      if (avail) begin
        busy  <= 1'b1;
        txd   <= 1'b0;
        frame <= {1'b1, head};
        sub   <= '0;
        bitn  <= '0;
      end
    end else if (tick) begin
      if (sub == SW'(OVERSAMPLE - 1)) begin
        sub <= '0;
        if (bitn == BW'(FRAME_BITS - 1)) begin
          busy <= 1'b0;
          txd  <= 1'b1;
        end else begin
          txd   <= frame[0];
          frame <= {1'b1, frame[W:1]};
          bitn  <= bitn + 1'b1;
        end
      end else begin
        sub <= sub + 1'b1;
      end
    end
  end

  a_r2_idle_high: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd);

  a_r2_start_low: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !txd);

  // R4: without a tick, a frame in flight keeps its level
  a_r4_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
    (busy && !tick) |=> $stable(txd));
endmodule

// File: rtl/uart_tx_top.sv
module uart_tx_top
  import uart_tx_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              txd,
  output logic              thr_empty
);
  localparam int unsigned DIV_W = 2 * DATA_W;

  reg_addr_e         ra;
  ctrl_t             ctrl;
  logic [DATA_W-1:0] div_lo, div_hi;
  logic              data_wr, dlo_wr, dhi_wr, ctrl_wr, flush;
  logic              tick, pop, avail, busy, buf_empty;
  logic [DATA_W-1:0] head;

  assign ra      = reg_addr_e'(addr);
  assign data_wr = wr_en && (ra == REG_DATA)  && !ctrl.latch_sel;
  assign dlo_wr  = wr_en && (ra == REG_DATA)  &&  ctrl.latch_sel;
  assign dhi_wr  = wr_en && (ra == REG_DIVHI) &&  ctrl.latch_sel;
  assign ctrl_wr = wr_en && (ra == REG_CTRL);
  assign flush   = ctrl_wr && (wdata[0] != ctrl.queue_en);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl   <= '0;
      div_lo <= '0;
      div_hi <= '0;
    end else begin
      if (ctrl_wr) ctrl   <= ctrl_t'(wdata[1:0]);
      if (dlo_wr)  div_lo <= wdata;
      if (dhi_wr)  div_hi <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      case (ra)
        REG_DATA:  rdata <= ctrl.latch_sel ? div_lo : '0;
        REG_DIVHI: rdata <= ctrl.latch_sel ? div_hi : '0;
        REG_CTRL:  rdata <= DATA_W'(ctrl);
        default:   rdata <= DATA_W'({busy, buf_empty});
      endcase
    end
  end

  baud_tick_gen #(.DIV_W(DIV_W)) u_baud (
    .clk     (clk),
    .rst     (rst),
    .restart (dlo_wr || dhi_wr),
    .divisor ({div_hi, div_lo}),
    .tick    (tick)
  );

  tx_byte_buffer #(.DEPTH(FIFO_DEPTH), .W(DATA_W)) u_buf (
    .clk      (clk),
    .rst      (rst),
    .queue_en (ctrl.queue_en),
    .flush    (flush),
    .wr       (data_wr),
    .wdata    (wdata),
    .pop      (pop),
    .avail    (avail),
    .head     (head),
    .empty    (buf_empty)
  );

  tx_shifter #(.W(DATA_W)) u_shift (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick),
    .avail (avail),
    .head  (head),
    .pop   (pop),
    .txd   (txd),
    .busy  (busy)
  );

  assign thr_empty = buf_empty;

  // R5: with the latch select set, a write to address 0 queues nothing
  a_r5_latch_blocks_data: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ra == REG_DATA && ctrl.latch_sel && thr_empty) |=> thr_empty);
endmodule

// File: tb/sim_uart_tx_top.sv
`timescale 1ns/1ps
module sim_uart_tx_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       txd, thr_empty;

  int checks = 0;
  int fails  = 0;
  bit qmode  = 1'b0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  uart_tx_top u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .txd(txd), .thr_empty(thr_empty)
  );

  // {divisor[15:0], byte[7:0], queue_en}
  localparam logic [24:0] VEC [0:5] = '{
    {16'd1, 8'h55, 1'b0},
    {16'd2, 8'hA5, 1'b1},
    {16'd1, 8'h80, 1'b1},
    {16'd3, 8'h01, 1'b0},
    {16'd2, 8'hFF, 1'b0},
    {16'd1, 8'h00, 1'b1}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic set_ctrl(input bit latch);
    wr(2'd2, {6'b0, latch, qmode});
  endtask

  task automatic set_div(input int d);
    set_ctrl(1'b1);
    wr(2'd0, d[7:0]);
    wr(2'd1, d[15:8]);
    set_ctrl(1'b0);
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic stays_high(input int n, input string tag);
    bit ok = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) ok = 1'b0;
    end
    chk(ok, tag, 0, 1);
  endtask

  task automatic recv(input int d, output logic [7:0] b, output bit ok);
    int t = 0;
    ok = 1'b0;
    b  = 8'h00;
    while (txd !== 1'b0 && t < 4000) begin
      @(negedge clk);
      t++;
    end
    if (txd !== 1'b0) return;
    wait_cycles(8 * d);
    if (txd !== 1'b0) return;
    for (int i = 0; i < 8; i++) begin
      wait_cycles(16 * d);
      b[i] = txd;
    end
    wait_cycles(16 * d);
    ok = (txd === 1'b1);
  endtask

  task automatic low_len(input int d, input string tag);
    int n = 0;
    int t = 0;
    wr(2'd0, 8'h00);
    while (txd !== 1'b0 && t < 200) begin
      @(negedge clk);
      t++;
    end
    while (txd === 1'b0 && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(n > 144 * d - d && n <= 144 * d, tag, n, 144 * d);
    wait_cycles(16 * d);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    bit ok;
    wait_cycles(4);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    chk(txd === 1'b1, "R1 txd", txd, 1);
    chk(thr_empty === 1'b1, "R1 empty", thr_empty, 1);
    rd(2'd2, r); chk(r == 8'h00, "R1 ctrl", r, 0);
    rd(2'd3, r); chk(r == 8'h01, "R1 status", r, 1);
    set_ctrl(1'b1);
    rd(2'd0, r); chk(r == 8'h00, "R1 div lo", r, 0);
    rd(2'd1, r); chk(r == 8'h00, "R1 div hi", r, 0);

    // R5: latch select routes address 0/1 to the divisor
    wr(2'd0, 8'h05);
    wr(2'd1, 8'h00);
    rd(2'd0, r); chk(r == 8'h05, "R5 div lo readback", r, 5);
    rd(2'd1, r); chk(r == 8'h00, "R5 div hi readback", r, 0);
    chk(thr_empty === 1'b1, "R5 no byte queued", thr_empty, 1);
    stays_high(200, "R5 line idle after divisor write");
    set_ctrl(1'b0);
    rd(2'd0, r); chk(r == 8'h00, "R5 data reads zero", r, 0);
    wr(2'd1, 8'h77);
    set_ctrl(1'b1);
    rd(2'd1, r); chk(r == 8'h00, "R5 high ignored when clear", r, 0);
    set_ctrl(1'b0);

    // R2/R3/R10: table walk across divisors, patterns and modes
    for (int v = 0; v < 6; v++) begin
      qmode = VEC[v][0];
      set_div(int'(VEC[v][24:9]));
      wr(2'd0, VEC[v][8:1]);
      recv(int'(VEC[v][24:9]), r, ok);
      chk(ok, "R2 framing", ok, 1);
      chk(r == VEC[v][8:1], "R2 R10 data bits", r, VEC[v][8:1]);
      stays_high(40, "R2 idle between frames");
    end

    // R3 and R10: bit period before and after a divisor reload
    qmode = 1'b0;
    set_div(3);
    low_len(3, "R3 period divisor 3");
    set_div(2);
    low_len(2, "R10 period after reload");

    // R4, R6, R8: stall with zero divisor, then overwrite
    set_div(0);
    wr(2'd0, 8'hA1);
    wait_cycles(100);
    chk(txd === 1'b0, "R4 start held", txd, 0);
    rd(2'd3, r); chk(r == 8'h03, "R8 status busy empty", r, 3);
    wr(2'd0, 8'hB2);
    chk(thr_empty === 1'b0, "R8 empty drops", thr_empty, 0);
    wr(2'd0, 8'hC3);
    set_div(1);
    recv(1, r, ok); chk(ok && r == 8'hA1, "R4 stalled frame", r, 8'hA1);
    recv(1, r, ok); chk(ok && r == 8'hC3, "R6 newest byte sent", r, 8'hC3);
    chk(thr_empty === 1'b1, "R8 empty after send", thr_empty, 1);
    stays_high(300, "R6 overwritten byte not sent");

    // R7: queue of 16, extra write dropped
    set_div(0);
    qmode = 1'b1;
    set_ctrl(1'b0);
    wr(2'd0, 8'h40);
    for (int i = 0; i < 16; i++) wr(2'd0, 8'h50 + 8'(i));
    wr(2'd0, 8'hEE);
    chk(thr_empty === 1'b0, "R7 queue holds bytes", thr_empty, 0);
    set_div(1);
    recv(1, r, ok); chk(ok && r == 8'h40, "R7 first frame", r, 8'h40);
    for (int i = 0; i < 16; i++) begin
      recv(1, r, ok);
      chk(ok && r == 8'h50 + 8'(i), "R7 queued order", r, 8'h50 + i);
    end
    stays_high(300, "R7 extra write dropped");
    chk(thr_empty === 1'b1, "R7 drained", thr_empty, 1);

    // R9: mode change discards waiting bytes, current frame finishes
    set_div(0);
    wr(2'd0, 8'h3C);
    wr(2'd0, 8'h11);
    wr(2'd0, 8'h22);
    qmode = 1'b0;
    set_ctrl(1'b0);
    chk(thr_empty === 1'b1, "R9 flushed", thr_empty, 1);
    set_div(2);
    recv(2, r, ok); chk(ok && r == 8'h3C, "R9 frame completes", r, 8'h3C);
    stays_high(400, "R9 nothing after flush");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule